// File: doc/BRIEF.md
# Three-Phase Hall Commutation Controller

This block turns the three digitised Hall sensor levels of a brushless motor into six gate enables for a three-phase bridge. Each phase has one high-side enable and one low-side enable, so each phase is driven high, driven low, or left floating. The bridge is chopped by pulse-width modulation on the low-side switch only. The high-side switch of the active phase stays on for the whole commutation state.

A current-limit comparator input can cut the low side short within a PWM period. The input is blanked for a programmable number of cycles after each low-side turn-on, so that diode recovery spikes cannot cause a trip. An active-low run input, a deceleration request with a choice between coasting and reverse-torque braking, and a protection kill input decide whether the bridge is driven at all. Every output is registered, so each result appears at the clock edge that follows its cause.

Top module: `hall_commutator`

## Requirements
- R1: `hall_lvl` is {sensor1, sensor2, sensor3}, with bit 2 being sensor 1. Bit i of `hs_en` and `ls_en` belongs to phase i+1. While running, with `pwm_on` high and no trip, the decode is: 101 gives phases (low, high, float); 100 gives (low, float, high); 110 gives (float, low, high); 010 gives (high, low, float); 011 gives (high, float, low); 001 gives (float, high, low). High means hs=1 and ls=0, low means hs=0 and ls=1, and float means both are 0.
- R2: Hall codes 000 and 111 turn all six enables off.
- R3: `pwm_on` gates only the low-side enable of the phase that is driven low. The high-side enables do not depend on `pwm_on`.
- R4: A high `ilim_trip` is ignored while it is sampled in the first BLANK_CYC cycles in which `pwm_on` is high after a low-to-high change of `pwm_on`. From the following cycle on, a high `ilim_trip` turns the low side off at the next edge.
- R5: After a trip has been accepted, the low side stays off, even if `ilim_trip` falls, until the next low-to-high change of `pwm_on`. It is on again at the edge that samples that change.
- R6: While `run_n` is high, all enables are off.
- R7: With `decel_req` high and `coast_sel` high (free running), all enables are off.
- R8: With `decel_req` high and `coast_sel` low (reverse torque), every phase that R1 drives high is driven low and every phase that R1 drives low is driven high. Floating phases stay floating, and the low side is still PWM gated.
- R9: `force_off` high turns all enables off at the next clock edge.
- R10: The outputs are registered with one cycle of latency and are all 0 during reset. A phase never has both of its enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_lvl | input | 3 | Digitised Hall levels, bit 2 = sensor 1 |
| pwm_on | input | 1 | PWM enable from the carrier comparator, high = on-time |
| ilim_trip | input | 1 | Current-limit comparator output, high = over limit |
| run_n | input | 1 | Run command, low = run, high = stop |
| coast_sel | input | 1 | Braking choice, high = coast, low = reverse torque |
| decel_req | input | 1 | Deceleration in progress |
| force_off | input | 1 | Protection kill, high = all switches off |
| hs_en | output | 3 | High-side enables, bit i = phase i+1 |
| ls_en | output | 3 | Low-side enables, bit i = phase i+1 |

## Verification
Every decode, stop, coast, reverse and kill result is due at the first clock edge after the stimulus. The bench drives inputs on the falling edge and samples shortly after the next rising edge. For current limiting, the edge that first samples `pwm_on` high is counted as blanking cycle 0. A trip held from that edge must leave the low side on for BLANK_CYC sampled edges and must turn it off at the edge after that. The bench steps exactly those counts. It then checks that the low side stays off after the trip falls, and that it returns at the edge that samples the next rise of `pwm_on`.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        PH_OFF = 2'd0,
        PH_HI  = 2'd1,
        PH_LO  = 2'd2
    } phase_e;

    typedef phase_e [NPH-1:0] phase_vec_t;

    typedef struct packed {
        logic stop;
        logic kill;
        logic decel;
        logic coast;
    } drive_ctl_t;

    // index 0 is phase 1; code bit 2 is sensor 1
    function automatic phase_vec_t hall_to_phase(input logic [2:0] code);
        phase_vec_t v;
        for (int i = 0; i < NPH; i++) v[i] = PH_OFF;
        case (code)
            3'b101: begin v[0] = PH_LO; v[1] = PH_HI; end
            3'b100: begin v[0] = PH_LO; v[2] = PH_HI; end
            3'b110: begin v[1] = PH_LO; v[2] = PH_HI; end
            3'b010: begin v[0] = PH_HI; v[1] = PH_LO; end
            3'b011: begin v[0] = PH_HI; v[2] = PH_LO; end
            3'b001: begin v[1] = PH_HI; v[2] = PH_LO; end
            default: ;
        endcase
        return v;
    endfunction

    function automatic phase_e mirror(input phase_e p);
        case (p)
            PH_HI:   return PH_LO;
            PH_LO:   return PH_HI;
            default: return PH_OFF;
        endcase
    endfunction

endpackage

// File: rtl/hcc_phase_select.sv
module hcc_phase_select
    import hcc_pkg::*;
(
    input  logic [2:0]  hall,
    input  drive_ctl_t  ctl,
    output phase_vec_t  phase
);
    phase_vec_t base;
    logic       block;

    always_comb base = hall_to_phase(hall);

    assign block = ctl.stop | ctl.kill | (ctl.decel & ctl.coast);

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        assign phase[g] = block     ? PH_OFF :
                          ctl.decel ? mirror(base[g]) : base[g];
    end
endmodule

// File: rtl/hcc_blank_timer.sv
module hcc_blank_timer #(
    parameter int BLANK_CYC = 100,
    localparam int CNT_W = $clog2(BLANK_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_on,
    input  logic ilim,
    output logic ls_permit
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BLANK_CYC - 1);

    logic             pwm_q;
    logic [CNT_W-1:0] cnt;
    logic             trip_q;
    logic             period_start;
    logic             accept;

    assign period_start = pwm_on & ~pwm_q;
    assign accept       = ilim & pwm_on & ~period_start & (cnt == '0);
    assign ls_permit    = pwm_on & ~accept & (period_start | ~trip_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q  <= 1'b0;
            cnt    <= '0;
            trip_q <= 1'b0;
        end else begin
            pwm_q <= pwm_on;
            if (period_start)     cnt <= LOAD;
            else if (cnt != '0)   cnt <= cnt - 1'b1;
            if (period_start)     trip_q <= 1'b0;
            else if (accept)      trip_q <= 1'b1;
        end
    end
endmodule

// File: rtl/hcc_gate_reg.sv
module hcc_gate_reg
    import hcc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  phase_vec_t     phase,
    input  logic           ls_permit,
    output logic [NPH-1:0] hs_en,
    output logic [NPH-1:0] ls_en
);
    logic [NPH-1:0] hs_d;
    logic [NPH-1:0] ls_d;

    for (genvar g = 0; g < NPH; g++) begin : g_drv
        assign hs_d[g] = (phase[g] == PH_HI);
        assign ls_d[g] = (phase[g] == PH_LO) & ls_permit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_en <= '0;
            ls_en <= '0;
        end else begin
            hs_en <= hs_d;
            ls_en <= ls_d;
        end
    end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hcc_pkg::*;
#(
    parameter int BLANK_CYC = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_lvl,
    input  logic       pwm_on,
    input  logic       ilim_trip,
    input  logic       run_n,
    input  logic       coast_sel,
    input  logic       decel_req,
    input  logic       force_off,
    output logic [2:0] hs_en,
    output logic [2:0] ls_en
);
    drive_ctl_t ctl;
    phase_vec_t phase;
    logic       ls_permit;

    always_comb begin
        ctl.stop  = run_n;
        ctl.kill  = force_off;
        ctl.decel = decel_req;
        ctl.coast = coast_sel;
    end

    hcc_phase_select i_sel (
        .hall  (hall_lvl),
        .ctl   (ctl),
        .phase (phase)
    );

    hcc_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_blank (
        .clk       (clk),
        .rst       (rst),
        .pwm_on    (pwm_on),
        .ilim      (ilim_trip),
        .ls_permit (ls_permit)
    );

    hcc_gate_reg i_gate (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .ls_permit (ls_permit),
        .hs_en     (hs_en),
        .ls_en     (ls_en)
    );
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] hall_lvl,
    input logic       pwm_on,
    input logic       run_n,
    input logic       coast_sel,
    input logic       decel_req,
    input logic       force_off,
    input logic [2:0] hs_en,
    input logic [2:0] ls_en
);
    a_r10_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
        (hs_en & ls_en) == 3'b000);

    a_r9_kill_next_edge: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (hs_en == 3'b000 && ls_en == 3'b000));

    a_r6_stop_all_off: assert property (@(posedge clk) disable iff (rst)
        run_n |=> (hs_en == 3'b000 && ls_en == 3'b000));

    a_r7_coast_all_off: assert property (@(posedge clk) disable iff (rst)
        (decel_req && coast_sel) |=> (hs_en == 3'b000 && ls_en == 3'b000));

    a_r2_illegal_off: assert property (@(posedge clk) disable iff (rst)
        (hall_lvl == 3'b000 || hall_lvl == 3'b111) |=> (hs_en == 3'b000 && ls_en == 3'b000));

    a_r3_ls_needs_pwm: assert property (@(posedge clk) disable iff (rst)
        !pwm_on |=> ls_en == 3'b000);

    a_r3_hs_ignores_pwm: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(hall_lvl) && $stable(run_n) && $stable(coast_sel)
         && $stable(decel_req) && $stable(force_off)) |=> $stable(hs_en));
endmodule

bind hall_commutator hall_commutator_chk i_chk (.*);

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
    localparam int BLANK = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_lvl = 3'b101;
    logic       pwm_on = 1'b0;
    logic       ilim_trip = 1'b0;
    logic       run_n = 1'b1;
    logic       coast_sel = 1'b1;
    logic       decel_req = 1'b0;
    logic       force_off = 1'b0;
    logic [2:0] hs_en;
    logic [2:0] ls_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hall_commutator #(.BLANK_CYC(BLANK)) i_hall_commutator (.*);

    // expected {hs,ls} for a legal code with full PWM on-time
    function automatic logic [5:0] exp_drive(input logic [2:0] c);
        case (c)
            3'b101: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b110: return {3'b100, 3'b010};
            3'b010: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b001: return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [2:0] ehs, input logic [2:0] els);
        total++;
        if (hs_en !== ehs || ls_en !== els) begin
            bad++;
            $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_en, ls_en, ehs, els);
        end
    endtask

    task automatic t_reset();
        step(2);
        check("R10 reset", 3'b000, 3'b000);
        @(negedge clk);
        rst = 1'b0; run_n = 1'b0; coast_sel = 1'b1; pwm_on = 1'b1;
        step(1);
    endtask

    task automatic t_table();
        logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        for (int i = 0; i < 6; i++) begin
            logic [5:0] e;
            @(negedge clk); hall_lvl = codes[i];
            step(1);
            e = exp_drive(codes[i]);
            check("R1 decode", e[5:3], e[2:0]);
        end
    endtask

    task automatic t_illegal();
        @(negedge clk); hall_lvl = 3'b000; step(1);
        check("R2 code 000", 3'b000, 3'b000);
        @(negedge clk); hall_lvl = 3'b111; step(1);
        check("R2 code 111", 3'b000, 3'b000);
        @(negedge clk); hall_lvl = 3'b110; step(1);
        check("R1 after illegal", 3'b100, 3'b010);
    endtask

    task automatic t_pwm();
        @(negedge clk); hall_lvl = 3'b101; pwm_on = 1'b0; step(1);
        check("R3 pwm off", 3'b010, 3'b000);
        @(negedge clk); pwm_on = 1'b1; step(1);
        check("R3 pwm on", 3'b010, 3'b001);
    endtask

    task automatic t_stop_kill();
        @(negedge clk); run_n = 1'b1; step(1);
        check("R6 stop", 3'b000, 3'b000);
        @(negedge clk); run_n = 1'b0; step(1);
        check("R6 restart", 3'b010, 3'b001);
        @(negedge clk); force_off = 1'b1; step(1);
        check("R9 kill", 3'b000, 3'b000);
        @(negedge clk); force_off = 1'b0; step(1);
        check("R9 release", 3'b010, 3'b001);
    endtask

    task automatic t_decel();
        logic [5:0] e;
        @(negedge clk); decel_req = 1'b1; coast_sel = 1'b1; step(1);
        check("R7 coast", 3'b000, 3'b000);
        @(negedge clk); coast_sel = 1'b0; hall_lvl = 3'b011; step(1);
        e = exp_drive(3'b011);
        check("R8 reverse 011", e[2:0], e[5:3]);
        @(negedge clk); hall_lvl = 3'b100; step(1);
        e = exp_drive(3'b100);
        check("R8 reverse 100", e[2:0], e[5:3]);
        @(negedge clk); pwm_on = 1'b0; step(1);
        check("R8 reverse pwm off", e[2:0], 3'b000);
        @(negedge clk); pwm_on = 1'b1; decel_req = 1'b0; coast_sel = 1'b1; hall_lvl = 3'b101; step(1);
        check("R8 end of decel", 3'b010, 3'b001);
    endtask

    task automatic t_blank();
        @(negedge clk); pwm_on = 1'b0; step(1);
        @(negedge clk); pwm_on = 1'b1; ilim_trip = 1'b1;
        step(BLANK);
        check("R4 blanked", 3'b010, 3'b001);
        step(1);
        check("R4 trip honoured", 3'b010, 3'b000);
        @(negedge clk); ilim_trip = 1'b0; step(3);
        check("R5 held off", 3'b010, 3'b000);
        @(negedge clk); pwm_on = 1'b0; step(1);
        @(negedge clk); pwm_on = 1'b1; step(1);
        check("R5 new period", 3'b010, 3'b001);
        step(BLANK + 2);
        @(negedge clk); ilim_trip = 1'b1; step(1);
        check("R4 late trip", 3'b010, 3'b000);
        @(negedge clk); ilim_trip = 1'b0; step(1);
    endtask

    initial begin
        t_reset();
        t_table();
        t_illegal();
        t_pwm();
        t_stop_kill();
        t_decel();
        t_blank();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule